// File: doc/BRIEF.md
# Autovectored Priority Interrupt Controller

This block gathers the interrupt requests of a processor subsystem and reduces them to one three-bit priority code for the core. There are 57 sources. Fifty are internal peripheral lines that are sensed as levels. Seven come from general-purpose pins, which are sensed by edge. Each pin can be set to react to its rising or to its falling transition. Software gives every source a priority from 1 to 7, or 0 to take it out of arbitration, and it can also mask each source with an enable bit.

The core reads `irqLevel`, which is registered every cycle, to learn the most urgent level that is waiting. No vector number is supplied. Each level maps to a fixed handler, so dispatch is autovectored. When the core acknowledges a level, the controller records the lowest-numbered source that requests that level. Software can then find the device to service without scanning the whole array. A pin event is held in a sticky bit until software clears it.

Top module: `autovecIntc`

## Requirements
- R1: After synchronous reset `irqLevel` is 0, and every register reads 0: priorities, enables, pin polarity, pin pending and acknowledge status.
- R2: Priorities live in words at addresses 0 to 7. Source s uses word s/8, bits [(s%8)*4+2 : (s%8)*4]. Bit 3 of each nibble reads 0, and so do the nibbles of nonexistent sources (sources 57 to 63 in word 7).
- R3: One cycle after its inputs, `irqLevel` equals the largest priority among the sources that are requesting, enabled and nonzero. It is 0 when there is no such source.
- R4: A source whose priority is 0, or whose enable bit is 0, never raises `irqLevel`, even while it requests.
- R5: Pin k (sources 50+k) is sampled through two flops. The polarity word at address 8 selects the edge: bit k = 1 for rising, 0 for falling. Only the selected transition sets bit k of the pending word at address 9, and the bit is set within four cycles of the pin change.
- R6: A pending pin bit stays set after the pin returns and after further edges. Writing 1 to that bit at address 9 clears it. Writing 0 leaves it unchanged.
- R7: Internal sources 0 to 49 are level-sensitive. When a request is withdrawn, its contribution leaves `irqLevel` on the next cycle, with no clearing write.
- R8: A cycle with `ackValid` high and `ackLevel` = L loads the status word at address 10, which is visible on the next cycle. Bits 5:0 hold the lowest source index that is requesting, enabled and at priority L, and bit 8 is 1. When no source matches, or L is 0, the word is 0. The word does not change in cycles without an acknowledge.
- R9: Enables are at address 11 (bit s for sources 0 to 31) and address 12 (bit s-32 for sources 32 to 56). Bits with no source behind them read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| intReq | input | 50 | Internal level requests, sources 0 to 49 |
| gpioPin | input | 7 | Asynchronous pin inputs, sources 50 to 56 |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| ackValid | input | 1 | Core acknowledge strobe |
| ackLevel | input | 3 | Priority level being acknowledged |
| irqLevel | output | 3 | Highest pending enabled priority, 0 when idle |

## Verification
The hardest case to reach from the ports is an acknowledge where several enabled, requesting sources share the acknowledged level and still others sit at different levels. Only then does the lowest-index rule differ from any other choice. It also has to happen while latched pin bits take part next to internal levels. The bench gets there by rewriting all eight priority words with random values restricted to 0 to 7, randomising both enable words, and driving sparse random internal requests. Each round it toggles a random pin under a random polarity and then acknowledges a random level. Directed cases add a tie between two sources at the same level, a level-0 acknowledge and a level with no match.

// File: rtl/icPkg.sv
`timescale 1ns/1ps
package icPkg;
  localparam int ADDR_W          = 4;
  localparam int DATA_W          = 32;
  localparam int LVL_W           = 3;
  localparam int FIELD_W         = 4;
  localparam int FIELDS_PER_WORD = DATA_W / FIELD_W;
  localparam int LVL_WORDS       = 8;
  localparam int ACK_FOUND_BIT   = 8;

  localparam logic [ADDR_W-1:0] ADDR_POL  = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_ACK  = 4'd10;
  localparam logic [ADDR_W-1:0] ADDR_ENLO = 4'd11;
  localparam logic [ADDR_W-1:0] ADDR_ENHI = 4'd12;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic [LVL_WORDS-1:0] lvlWordWr;
    logic                 polWr;
    logic                 pendClr;
    logic                 enLoWr;
    logic                 enHiWr;
    logic                 ackStb;
    logic [LVL_W-1:0]     ackLvl;
  } icStrobes_t;
endpackage

// File: rtl/icControl.sv
`timescale 1ns/1ps
module icControl
  import icPkg::*;
(
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  output icStrobes_t        strb
);
  always_comb begin
    strb = '0;
    if (regWe) begin
      if (regAddr[ADDR_W-1] == 1'b0) begin
        strb.lvlWordWr[regAddr[2:0]] = 1'b1;
      end else begin
        unique case (regAddr)
          ADDR_POL:  strb.polWr   = 1'b1;
          ADDR_PEND: strb.pendClr = 1'b1;
          ADDR_ENLO: strb.enLoWr  = 1'b1;
          ADDR_ENHI: strb.enHiWr  = 1'b1;
          default:   ;
        endcase
      end
    end
    strb.ackStb = ackValid;
    strb.ackLvl = ackLevel;
  end
endmodule

// File: rtl/icDatapath.sv
`timescale 1ns/1ps
module icDatapath
  import icPkg::*;
#(
  parameter int NUM_LEVEL = 50,
  parameter int NUM_EDGE  = 7
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LEVEL-1:0] intReq,
  input  logic [NUM_EDGE-1:0]  gpioPin,
  input  icStrobes_t           strb,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic [LVL_W-1:0]     irqLevel,
  output logic [NUM_EDGE-1:0]  edgePend,
  output logic [NUM_EDGE-1:0]  syncEdge,
  output logic [DATA_W-1:0]    ackWord
);
  localparam int NUM_SRC = NUM_LEVEL + NUM_EDGE;
  localparam int IDX_W   = $clog2(NUM_SRC);

  // Programmable per-source state
  logic [LVL_W-1:0] srcLvl [NUM_SRC];
  logic             srcEn  [NUM_SRC];

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int WORD = i / FIELDS_PER_WORD;
      localparam int SLOT = i % FIELDS_PER_WORD;
      always_ff @(posedge clk) begin
        if (rst)                        srcLvl[i] <= '0;
        else if (strb.lvlWordWr[WORD])  srcLvl[i] <= regWrData[SLOT*FIELD_W +: LVL_W];
      end
      if (i < DATA_W) begin : g_enLo
        always_ff @(posedge clk) begin
          if (rst)              srcEn[i] <= 1'b0;
          else if (strb.enLoWr) srcEn[i] <= regWrData[i];
        end
      end else begin : g_enHi
        always_ff @(posedge clk) begin
          if (rst)              srcEn[i] <= 1'b0;
          else if (strb.enHiWr) srcEn[i] <= regWrData[i - DATA_W];
        end
      end
    end
  endgenerate

  // Pin synchroniser, edge select and sticky pending
  logic [NUM_EDGE-1:0] edgeRise, pinS1, pinS2, pinPrev, edgeHit, clrMask;

  always_ff @(posedge clk) begin
    if (rst) begin
      pinS1 <= '0; pinS2 <= '0; pinPrev <= '0; edgeRise <= '0;
    end else begin
      pinS1   <= gpioPin;
      pinS2   <= pinS1;
      pinPrev <= pinS2;
      if (strb.polWr) edgeRise <= regWrData[NUM_EDGE-1:0];
    end
  end

  assign syncEdge = pinS2 ^ pinPrev;
  assign edgeHit  = syncEdge & ~(pinS2 ^ edgeRise);
  assign clrMask  = strb.pendClr ? regWrData[NUM_EDGE-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) edgePend <= '0;
    else     edgePend <= (edgePend & ~clrMask) | edgeHit;
  end

  // Arbitration
  logic [NUM_SRC-1:0] reqAll;
  logic [LVL_W-1:0]   effLvl [NUM_SRC];
  logic [LVL_W-1:0]   maxLvl;
  logic               hitFound;
  logic [IDX_W-1:0]   hitIdx;

  assign reqAll = {edgePend, intReq};

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      effLvl[i] = (reqAll[i] && srcEn[i]) ? srcLvl[i] : '0;
  end

  always_comb begin
    maxLvl = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (effLvl[i] > maxLvl) maxLvl = effLvl[i];
  end

  always_comb begin
    hitFound = 1'b0;
    hitIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (strb.ackLvl != '0 && effLvl[i] == strb.ackLvl) begin
        hitFound = 1'b1;
        hitIdx   = IDX_W'(i);
      end
    end
  end

  logic             ackFound;
  logic [IDX_W-1:0] ackIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      irqLevel <= '0;
      ackFound <= 1'b0;
      ackIdx   <= '0;
    end else begin
      irqLevel <= maxLvl;
      if (strb.ackStb) begin
        ackFound <= hitFound;
        ackIdx   <= hitIdx;
      end
    end
  end

  always_comb begin
    ackWord                = '0;
    ackWord[IDX_W-1:0]     = ackIdx;
    ackWord[ACK_FOUND_BIT] = ackFound;
  end

  // Read-back views
  logic [DATA_W-1:0] lvlView [LVL_WORDS];
  logic [DATA_W-1:0] enLoView, enHiView;

  always_comb begin
    for (int w = 0; w < LVL_WORDS; w++) lvlView[w] = '0;
    for (int i = 0; i < NUM_SRC; i++)
      lvlView[i / FIELDS_PER_WORD][(i % FIELDS_PER_WORD)*FIELD_W +: FIELD_W] =
        {{(FIELD_W-LVL_W){1'b0}}, srcLvl[i]};
  end

  always_comb begin
    enLoView = '0;
    enHiView = '0;
    for (int i = 0; i < NUM_SRC && i < DATA_W; i++) enLoView[i] = srcEn[i];
    for (int i = DATA_W; i < NUM_SRC; i++)          enHiView[i - DATA_W] = srcEn[i];
  end

  always_comb begin
    regRdData = '0;
    if (regAddr[ADDR_W-1] == 1'b0) begin
      regRdData = lvlView[regAddr[2:0]];
    end else begin
      unique case (regAddr)
        ADDR_POL:  regRdData[NUM_EDGE-1:0] = edgeRise;
        ADDR_PEND: regRdData[NUM_EDGE-1:0] = edgePend;
        ADDR_ACK:  regRdData = ackWord;
        ADDR_ENLO: regRdData = enLoView;
        ADDR_ENHI: regRdData = enHiView;
        default:   regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/autovecIntc.sv
`timescale 1ns/1ps
module autovecIntc
  import icPkg::*;
#(
  parameter int NUM_LEVEL = 50,
  parameter int NUM_EDGE  = 7
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LEVEL-1:0] intReq,
  input  logic [NUM_EDGE-1:0]  gpioPin,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic                 ackValid,
  input  logic [LVL_W-1:0]     ackLevel,
  output logic [LVL_W-1:0]     irqLevel
);
  icStrobes_t          strb;
  logic [NUM_EDGE-1:0] edgePendW;
  logic [NUM_EDGE-1:0] syncEdgeW;
  logic [DATA_W-1:0]   ackWordW;

  icControl u_ctl (
    .regWe    (regWe),
    .regAddr  (regAddr),
    .ackValid (ackValid),
    .ackLevel (ackLevel),
    .strb     (strb)
  );

  icDatapath #(.NUM_LEVEL(NUM_LEVEL), .NUM_EDGE(NUM_EDGE)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .intReq    (intReq),
    .gpioPin   (gpioPin),
    .strb      (strb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqLevel  (irqLevel),
    .edgePend  (edgePendW),
    .syncEdge  (syncEdgeW),
    .ackWord   (ackWordW)
  );
endmodule

// File: rtl/icChecker.sv
`timescale 1ns/1ps
module icChecker
  import icPkg::*;
#(
  parameter int NUM_LEVEL = 50,
  parameter int NUM_EDGE  = 7
)(
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LEVEL-1:0] intReq,
  input logic                 regWe,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 ackValid,
  input logic [LVL_W-1:0]     irqLevel,
  input logic [NUM_EDGE-1:0]  edgePend,
  input logic [NUM_EDGE-1:0]  syncEdge,
  input logic [DATA_W-1:0]    ackWord
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> irqLevel == '0);

  // R3
  irq_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
    (irqLevel != '0) |-> $past((|intReq) || (|edgePend)));

  // R5
  pend_set_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (|(edgePend & ~$past(edgePend))) |-> $past(|syncEdge));

  // R6
  pend_clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(edgePend) & ~edgePend)) |-> $past(regWe && regAddr == ADDR_PEND));

  // R8
  ack_status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ackValid |=> $stable(ackWord));
endmodule

bind autovecIntc icChecker #(.NUM_LEVEL(NUM_LEVEL), .NUM_EDGE(NUM_EDGE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .intReq   (intReq),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .ackValid (ackValid),
  .irqLevel (irqLevel),
  .edgePend (edgePendW),
  .syncEdge (syncEdgeW),
  .ackWord  (ackWordW)
);

// File: tb/autovecIntc_bench.sv
`timescale 1ns/1ps
module autovecIntc_bench;
  localparam int NL = 50;
  localparam int NE = 7;
  localparam int NS = NL + NE;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] intReq = '0;
  logic [NE-1:0] gpioPin = '0;
  logic          regWe = 1'b0;
  logic [3:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          ackValid = 1'b0;
  logic [2:0]    ackLevel = '0;
  logic [2:0]    irqLevel;

  always #4 clk = ~clk;

  autovecIntc #(.NUM_LEVEL(NL), .NUM_EDGE(NE)) u_autovecIntc (
    .clk(clk), .rst(rst), .intReq(intReq), .gpioPin(gpioPin),
    .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .ackValid(ackValid), .ackLevel(ackLevel), .irqLevel(irqLevel)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model built from the requirements
  logic [2:0]    mLvl [NS];
  logic          mEn  [NS];
  logic [NE-1:0] mPol = '0;
  logic [NE-1:0] mPend = '0;
  logic [NL-1:0] mReq = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] expIrq();
    logic [2:0] m = 3'd0;
    for (int i = 0; i < NS; i++) begin
      logic r = (i < NL) ? mReq[i] : mPend[i - NL];
      if (r && mEn[i] && mLvl[i] > m) m = mLvl[i];
    end
    return m;
  endfunction

  function automatic logic [31:0] expAck(input logic [2:0] lv);
    logic [31:0] w = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      logic r = (i < NL) ? mReq[i] : mPend[i - NL];
      if (lv != 3'd0 && r && mEn[i] && mLvl[i] == lv) w = 32'h100 | 32'(i);
    end
    return w;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
    if (a < 4'd8) begin
      for (int j = 0; j < 8; j++)
        if (int'(a) * 8 + j < NS) mLvl[int'(a) * 8 + j] = d[j*4 +: 3];
    end else if (a == 4'd8) mPol = d[NE-1:0];
    else if (a == 4'd9)  mPend = mPend & ~d[NE-1:0];
    else if (a == 4'd11) begin for (int i = 0; i < 32; i++) mEn[i] = d[i]; end
    else if (a == 4'd12) begin for (int i = 32; i < NS; i++) mEn[i] = d[i - 32]; end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic setReq(input logic [NL-1:0] v);
    @(negedge clk);
    intReq = v; mReq = v;
  endtask

  task automatic checkIrq(input string req);
    @(negedge clk);
    chk(req, 32'(irqLevel), 32'(expIrq()));
  endtask

  task automatic pin(input int k, input logic v);
    @(negedge clk);
    if (gpioPin[k] != v && v == mPol[k]) mPend[k] = 1'b1;
    gpioPin[k] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic doAck(input logic [2:0] lv, input string req);
    logic [31:0] e, d;
    @(negedge clk);
    ackValid = 1'b1; ackLevel = lv;
    e = expAck(lv);
    @(negedge clk);
    ackValid = 1'b0;
    rd(4'd10, d);
    chk(req, d, e);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NS; i++) begin mLvl[i] = '0; mEn[i] = 1'b0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irqLevel", 32'(irqLevel), 32'd0);
    rd(4'd0, d);  chk("R1 level word", d, 32'd0);
    rd(4'd8, d);  chk("R1 polarity", d, 32'd0);
    rd(4'd9, d);  chk("R1 pending", d, 32'd0);
    rd(4'd10, d); chk("R1 ack status", d, 32'd0);
    rd(4'd11, d); chk("R1 enable lo", d, 32'd0);

    // R2 level packing and unused bits
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, d); chk("R2 nibble bit3", d, 32'h7777_7777);
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, d); chk("R2 last word", d, 32'h0000_0007);

    // R9 enable words
    wr(4'd12, 32'hFFFF_FFFF); rd(4'd12, d); chk("R9 enable hi", d, 32'h01FF_FFFF);
    wr(4'd11, 32'hFFFF_FFFF); rd(4'd11, d); chk("R9 enable lo", d, 32'hFFFF_FFFF);

    // R3 directed
    setReq(NL'(1) << 3); checkIrq("R3 source3 at 7");
    wr(4'd0, 32'h0000_1000); checkIrq("R3 source3 at 1");
    chk("R3 direct", 32'(irqLevel), 32'd1);

    // R4 level zero and mask
    wr(4'd0, 32'h0); checkIrq("R4 level zero");
    chk("R4 level zero", 32'(irqLevel), 32'd0);
    wr(4'd0, 32'h0000_1000); wr(4'd11, ~(32'd1 << 3)); checkIrq("R4 masked");
    chk("R4 masked", 32'(irqLevel), 32'd0);
    wr(4'd11, 32'hFFFF_FFFF);

    // R7 level withdrawal
    wr(4'd0, 32'h0000_5000); checkIrq("R7 raised");
    chk("R7 raised", 32'(irqLevel), 32'd5);
    setReq('0); checkIrq("R7 withdrawn");
    chk("R7 withdrawn", 32'(irqLevel), 32'd0);

    // R5 rising edge on pin 0, source 50 at level 6
    wr(4'd7, 32'h0);
    wr(4'd6, 32'h0000_0600);
    wr(4'd8, 32'h0000_0001);
    pin(0, 1'b1); rd(4'd9, d); chk("R5 rising sets", d, 32'h1);
    chk("R5 irq from pin", 32'(irqLevel), 32'd6);
    pin(0, 1'b0); rd(4'd9, d); chk("R6 sticky after fall", d, 32'h1);
    pin(1, 1'b1); rd(4'd9, d); chk("R5 rise ignored on falling pin", d, 32'h1);
    pin(1, 1'b0); rd(4'd9, d); chk("R5 falling sets", d, 32'h3);

    // R6 clear semantics
    wr(4'd9, 32'h0); rd(4'd9, d); chk("R6 zero write keeps", d, 32'h3);
    wr(4'd9, 32'h1); rd(4'd9, d); chk("R6 clear one bit", d, 32'h2);
    wr(4'd9, 32'h2); rd(4'd9, d); chk("R6 clear other", d, 32'h0);
    checkIrq("R6 irq after clear");

    // R8 acknowledge
    doAck(3'd4, "R8 no match");
    wr(4'd0, 32'h0030_0000); wr(4'd1, 32'h0000_0300);
    setReq((NL'(1) << 5) | (NL'(1) << 10));
    doAck(3'd3, "R8 lowest index tie");
    doAck(3'd0, "R8 level zero");

    // Random phase
    void'($urandom(32'd1234));
    for (int it = 0; it < 60; it++) begin
      int k;
      for (int w = 0; w < 8; w++) wr(4'(w), $urandom & 32'h7777_7777);
      wr(4'd11, $urandom); wr(4'd12, $urandom);
      if (it % 4 == 0) wr(4'd8, $urandom);
      setReq(NL'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}));
      checkIrq("R3 random");
      k = int'($urandom % NE);
      pin(k, ~gpioPin[k]);
      rd(4'd9, d); chk("R5 random pending", d, 32'(mPend));
      chk("R3 random with pins", 32'(irqLevel), 32'(expIrq()));
      doAck(3'($urandom % 8), "R8 random");
      if (it % 3 == 0) begin
        wr(4'd9, $urandom);
        rd(4'd9, d); chk("R6 random clear", d, 32'(mPend));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule